// File: doc/BRIEF.md
# Split-Mode Auto-Reload Timer

This block is a timer peripheral driven from a small register bus. It holds a byte-wide control register, two counter bytes and two reload bytes. With the split control bit clear, the two counter bytes form one 16-bit up-counter. When that counter wraps, it restarts from the 16-bit reload value. With the split bit set, the bytes act as two separate 8-bit counters. Each byte restarts from its own reload byte when it wraps.

The counting rate comes from a system-clock prescaler (divide by 12) or from an external clock input. The external clock is synchronized, edge-detected and divided by 8. A control bit chooses between these two sources. Two plain inputs, one per byte, can instead make a byte count on every system clock cycle. Two sticky wrap flags drive one interrupt request line. A global enable input gates that line.

The register bus is a plain single-cycle interface with no valid/ready handshake. A write takes effect at the clock edge where `bus_wr` is high, and it is never stalled. Reads are combinational from `bus_addr`. No data stream crosses the block edge, so there is no back-pressure.

Top module: `split_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: Register addresses are 0 control, 1 counter low, 2 counter high, 3 reload low, 4 reload high. The control register bits are:
  - bit 7: high wrap flag
  - bit 6: low wrap flag
  - bit 5: low interrupt enable
  - bit 3: split
  - bit 2: run
  - bit 0: external source select

  Bits 4 and 1 always read 0, so writing 0x3F reads back 0x2D.
- R3: With split = 0 and run = 1, the 16-bit count advances by one per count tick. From 0xFFFF it loads the 16-bit reload value and sets the high flag.
- R4: The low flag sets whenever the low byte passes 0xFF. In split mode the low byte then loads its reload byte. In 16-bit mode it goes to 0x00, or to the reload value on a full wrap.
- R5: Only a control write changes a flag. The written bit value is loaded, so writing 0 clears it. A hardware set in the same cycle overrides a written 0.
- R6: In 16-bit mode, run = 0 freezes both bytes. In split mode, run gates only the high byte, and the low byte counts regardless of run.
- R7: With the per-byte fast input low, a byte counts once every 12 system cycles when bit 0 = 0. With bit 0 = 1, it counts once per 8 external rising edges. With the per-byte fast input high, it counts every system cycle. In 16-bit mode the low byte's source drives the whole counter.
- R8: Each external rising edge is counted once, however long the external level is held.
- R9: `irq` equals `irq_gate` AND (high flag OR (low flag AND low interrupt enable)).
- R10: A bus write to a counter byte overrides a count step in the same cycle. The byte holds the written value.
- R11: In split mode with run = 1, the high byte counts on its own tick. It loads its reload byte after 0xFF and sets the high flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk | input | 1 | Asynchronous external count clock |
| lo_fast_clk | input | 1 | 1: low byte counts every system cycle |
| hi_fast_clk | input | 1 | 1: high byte counts every system cycle |
| irq_gate | input | 1 | Global timer interrupt enable |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
A register write and a fast-clock count step both show at the first sampling point after the edge that carries them. A wrap flag appears in the same cycle as the reload that caused it. `irq` follows the flags with no added register. The bench therefore drives inputs at a falling edge and compares every counter and flag against a cycle-stepped arithmetic model at each following falling edge. An external edge needs three system edges to reach the counter (two synchronizer flops and the edge detector), so the bench waits eight cycles before comparing. The 12-cycle prescaled rate is measured as the number of falling edges between two successive count changes.

// File: rtl/split_timer_pkg.sv
package split_timer_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_CNT_LO = 3'd1,
    REG_CNT_HI = 3'd2,
    REG_RLD_LO = 3'd3,
    REG_RLD_HI = 3'd4
  } reg_addr_e;

  localparam int BIT_HF    = 7;
  localparam int BIT_LF    = 6;
  localparam int BIT_LIE   = 5;
  localparam int BIT_SPLIT = 3;
  localparam int BIT_RUN   = 2;
  localparam int BIT_XSEL  = 0;
  localparam int LANES     = 2;
endpackage

// File: rtl/split_timer_ticks.sv
module split_timer_ticks #(
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clk,
  output logic sys_tick,
  output logic ext_tick,
  output logic ext_edge
);
  localparam int SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
  localparam int EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;

  logic [SW-1:0]          sys_cnt;
  logic [EW-1:0]          ext_cnt;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_prev;

  assign sys_tick = (sys_cnt == SW'(SYS_DIV - 1));
  assign ext_edge = sync_q[SYNC_STAGES-1] & ~edge_prev;
  assign ext_tick = ext_edge & (ext_cnt == EW'(EXT_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_cnt <= '0;
    end else if (sys_tick) begin
      sys_cnt <= '0;
    end else begin
      sys_cnt <= sys_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      edge_prev <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], ext_clk};
      edge_prev <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_cnt <= '0;
    end else if (ext_tick) begin
      ext_cnt <= '0;
    end else if (ext_edge) begin
      ext_cnt <= ext_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/split_timer_lane.sv
module split_timer_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         rld_wr,
  input  logic [W-1:0] wdata,
  input  logic         step,
  input  logic         reload,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic         at_max
);
  assign at_max = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= wdata;
    end else if (step) begin
      cnt <= reload ? rld : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld <= '0;
    end else if (rld_wr) begin
      rld <= wdata;
    end
  end
endmodule

// File: rtl/split_timer_ctrl.sv
module split_timer_ctrl
  import split_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  input  logic       hf_set,
  input  logic       lf_set,
  input  logic       irq_gate,
  output logic       hf,
  output logic       lf,
  output logic       lie,
  output logic       split,
  output logic       run,
  output logic       xsel,
  output logic [7:0] rdata,
  output logic       irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lie   <= 1'b0;
      split <= 1'b0;
      run   <= 1'b0;
      xsel  <= 1'b0;
    end else if (wr) begin
      lie   <= wdata[BIT_LIE];
      split <= wdata[BIT_SPLIT];
      run   <= wdata[BIT_RUN];
      xsel  <= wdata[BIT_XSEL];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hf <= 1'b0;
      lf <= 1'b0;
    end else begin
      hf <= hf_set | (wr ? wdata[BIT_HF] : hf);
      lf <= lf_set | (wr ? wdata[BIT_LF] : lf);
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[BIT_HF]    = hf;
    rdata[BIT_LF]    = lf;
    rdata[BIT_LIE]   = lie;
    rdata[BIT_SPLIT] = split;
    rdata[BIT_RUN]   = run;
    rdata[BIT_XSEL]  = xsel;
  end

  assign irq = irq_gate & (hf | (lf & lie));
endmodule

// File: rtl/split_timer.sv
module split_timer
  import split_timer_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYS_DIV     = 12,
  parameter int EXT_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk,
  input  logic              lo_fast_clk,
  input  logic              hi_fast_clk,
  input  logic              irq_gate,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int LO = 0;
  localparam int HI = 1;

  logic sys_tick, ext_tick, ext_edge;
  logic base_tick, lo_tick, hi_tick;
  logic ctl_hf, ctl_lf, ctl_lie, ctl_split, ctl_run, ctl_xsel;
  logic hf_set, lf_set, ctrl_wr;
  logic [7:0] ctrl_rdata;

  logic              lane_cnt_wr [LANES];
  logic              lane_rld_wr [LANES];
  logic              lane_step   [LANES];
  logic              lane_reload [LANES];
  logic              lane_max    [LANES];
  logic [BYTE_W-1:0] lane_cnt    [LANES];
  logic [BYTE_W-1:0] lane_rld    [LANES];
  logic [BYTE_W-1:0] cnt_lo, cnt_hi;

  split_timer_ticks #(
    .SYS_DIV(SYS_DIV), .EXT_DIV(EXT_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_ticks (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk),
    .sys_tick(sys_tick), .ext_tick(ext_tick), .ext_edge(ext_edge)
  );

  assign base_tick = ctl_xsel ? ext_tick : sys_tick;
  assign lo_tick   = lo_fast_clk | base_tick;
  assign hi_tick   = hi_fast_clk | base_tick;

  assign ctrl_wr        = bus_wr && (bus_addr == REG_CTRL);
  assign lane_cnt_wr[LO] = bus_wr && (bus_addr == REG_CNT_LO);
  assign lane_cnt_wr[HI] = bus_wr && (bus_addr == REG_CNT_HI);
  assign lane_rld_wr[LO] = bus_wr && (bus_addr == REG_RLD_LO);
  assign lane_rld_wr[HI] = bus_wr && (bus_addr == REG_RLD_HI);

  always_comb begin
    if (ctl_split) begin
      lane_step[LO]   = lo_tick & ~lane_cnt_wr[LO];
      lane_reload[LO] = lane_max[LO];
      lane_step[HI]   = ctl_run & hi_tick & ~lane_cnt_wr[HI];
      lane_reload[HI] = lane_max[HI];
    end else begin
      lane_step[LO]   = ctl_run & lo_tick & ~lane_cnt_wr[LO];
      lane_reload[LO] = lane_max[LO] & lane_max[HI];
      lane_step[HI]   = lane_step[LO] & lane_max[LO] & ~lane_cnt_wr[HI];
      lane_reload[HI] = lane_max[HI];
    end
  end

  assign lf_set = lane_step[LO] & lane_max[LO];
  assign hf_set = lane_step[HI] & lane_max[HI];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    split_timer_lane #(.W(BYTE_W)) u_lane (
      .clk(clk), .rst_n(rst_n),
      .cnt_wr(lane_cnt_wr[g]), .rld_wr(lane_rld_wr[g]), .wdata(bus_wdata),
      .step(lane_step[g]), .reload(lane_reload[g]),
      .cnt(lane_cnt[g]), .rld(lane_rld[g]), .at_max(lane_max[g])
    );
  end

  assign cnt_lo = lane_cnt[LO];
  assign cnt_hi = lane_cnt[HI];

  split_timer_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(bus_wdata[7:0]),
    .hf_set(hf_set), .lf_set(lf_set), .irq_gate(irq_gate),
    .hf(ctl_hf), .lf(ctl_lf), .lie(ctl_lie), .split(ctl_split),
    .run(ctl_run), .xsel(ctl_xsel), .rdata(ctrl_rdata), .irq(irq)
  );

  always_comb begin
    case (bus_addr)
      REG_CTRL:   bus_rdata = BYTE_W'(ctrl_rdata);
      REG_CNT_LO: bus_rdata = lane_cnt[LO];
      REG_CNT_HI: bus_rdata = lane_cnt[HI];
      REG_RLD_LO: bus_rdata = lane_rld[LO];
      REG_RLD_HI: bus_rdata = lane_rld[HI];
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/split_timer_checker.sv
module split_timer_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bus_wr,
  input logic [2:0]   bus_addr,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] bus_rdata,
  input logic         irq_gate,
  input logic         irq,
  input logic         ctl_hf,
  input logic         ctl_lf,
  input logic         ctl_split,
  input logic         ctl_run,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         ext_edge
);
  logic wr_ctrl, wr_lo, wr_hi;
  assign wr_ctrl = bus_wr && (bus_addr == 3'd0);
  assign wr_lo   = bus_wr && (bus_addr == 3'd1);
  assign wr_hi   = bus_wr && (bus_addr == 3'd2);

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd0) |-> (bus_rdata[4] == 1'b0 && bus_rdata[1] == 1'b0));

  assert_hf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hf && !wr_ctrl) |=> ctl_hf);

  assert_lf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_lf && !wr_ctrl) |=> ctl_lf);

  assert_split_hi_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_split && !ctl_run && !wr_hi) |=> $stable(cnt_hi));

  assert_stop16_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_split && !ctl_run && !wr_lo && !wr_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_gate |-> !irq);

  assert_irq_high_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_gate && ctl_hf) |-> irq);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (cnt_lo == $past(bus_wdata)));
endmodule

bind split_timer split_timer_checker #(.W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_gate(irq_gate), .irq(irq),
  .ctl_hf(ctl_hf), .ctl_lf(ctl_lf), .ctl_split(ctl_split), .ctl_run(ctl_run),
  .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ext_edge(ext_edge)
);

// File: tb/split_timer_bench.sv
`timescale 1ns/1ps
module split_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_clk = 1'b0;
  logic       lo_fast_clk = 1'b0;
  logic       hi_fast_clk = 1'b0;
  logic       irq_gate = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  split_timer u_split_timer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .lo_fast_clk(lo_fast_clk),
    .hi_fast_clk(hi_fast_clk), .irq_gate(irq_gate), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic stop_clear();
    wr(3'd0, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, lo, hi, ct;
    logic [15:0] m;
    logic mh, ml;
    int n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset irq", irq, 0);

    // R7 / R8: external source, 16 edges -> 2 counts
    wr(3'd0, 8'h05);
    for (int e = 0; e < 16; e++) begin
      ext_clk = 1'b1; repeat (4) @(negedge clk);
      ext_clk = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (8) @(negedge clk);
    rd(3'd1, v); chk("R7 external divide by 8", v, 2);
    ext_clk = 1'b1; repeat (40) @(negedge clk);
    rd(3'd1, v); chk("R8 held level counted once", v, 2);
    ext_clk = 1'b0; repeat (8) @(negedge clk);

    // R7: system prescaler divide by 12
    wr(3'd0, 8'h04);
    for (int k = 0; k < 3; k++) begin
      rd(3'd1, v); n = 0;
      do begin @(negedge clk); n++; rd(3'd1, lo); end while (lo == v && n < 40);
      if (k > 0) chk("R7 system divide by 12", n, 12);
    end

    // R2: control layout, unused bits
    stop_clear();
    wr(3'd0, 8'h3F);
    rd(3'd0, v); chk("R2 control readback", v, 8'h2D);
    stop_clear();
    rd(3'd0, v); chk("R2 control cleared", v, 8'h00);

    // R3 / R4: 16-bit sweep through low wraps and a full wrap
    lo_fast_clk = 1'b1;
    wr(3'd1, 8'hF0); wr(3'd2, 8'hFE); wr(3'd3, 8'h80); wr(3'd4, 8'hFF);
    wr(3'd0, 8'h04);
    m = 16'hFEF0; mh = 1'b0; ml = 1'b0;
    for (int c = 0; c < 600; c++) begin
      rd(3'd1, lo); rd(3'd2, hi); rd(3'd0, ct);
      chk("R3 16-bit count", {hi, lo}, m);
      chk("R4 flags in 16-bit mode", ct, {mh, ml, 6'b000100});
      @(negedge clk);
      if (m == 16'hFFFF) begin m = 16'hFF80; mh = 1'b1; ml = 1'b1; end
      else begin if (m[7:0] == 8'hFF) ml = 1'b1; m = m + 16'd1; end
    end

    // R4 / R6 / R11: split-mode low byte sweeps, run = 0
    for (int r = 0; r < 4; r++) begin
      logic [7:0] rl;
      rl = (r == 0) ? 8'h00 : (r == 1) ? 8'h80 : (r == 2) ? 8'hFE : 8'hFF;
      stop_clear();
      wr(3'd1, 8'h00); wr(3'd3, rl); wr(3'd2, 8'h5A); wr(3'd4, 8'h33);
      wr(3'd0, 8'h08);
      wr(3'd1, rl);
      lo = rl; ml = 1'b0;
      for (int c = 0; c < 300; c++) begin
        rd(3'd1, v);  chk("R11 split low reload", v, lo);
        rd(3'd2, hi); chk("R6 high gated by run", hi, 8'h5A);
        rd(3'd0, ct); chk("R4 low flag in split mode", ct, {1'b0, ml, 6'b001000});
        @(negedge clk);
        if (lo == 8'hFF) begin lo = rl; ml = 1'b1; end else lo = lo + 8'd1;
      end
    end

    // R11 / R6: split high byte with run = 1
    hi_fast_clk = 1'b1;
    stop_clear();
    wr(3'd4, 8'h10); wr(3'd2, 8'hFE);
    wr(3'd0, 8'h0C);
    for (int c = 0; c < 4; c++) begin
      rd(3'd2, hi); rd(3'd0, ct);
      chk("R11 split high count", hi, (c == 0) ? 8'hFE : (c == 1) ? 8'hFF : (c == 2) ? 8'h10 : 8'h11);
      chk("R11 high flag", ct[7], (c >= 2) ? 1 : 0);
      @(negedge clk);
    end
    hi_fast_clk = 1'b0;

    // R10: counter write beats a count step
    stop_clear();
    wr(3'd3, 8'h21);
    wr(3'd0, 8'h08);
    wr(3'd1, 8'h77);
    rd(3'd1, v); chk("R10 write wins over step", v, 8'h77);

    // R5: hardware set beats a written 0, then software clear
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'h08);
    rd(3'd0, v); chk("R5 hardware set wins", v, 8'h48);
    rd(3'd1, v); chk("R4 wrap loads reload byte", v, 8'h21);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R5 software clear", v, 8'h00);

    // R9: interrupt request
    wr(3'd0, 8'h40);
    #1; chk("R9 low flag without enable", irq, 0);
    wr(3'd0, 8'h60);
    #1; chk("R9 low flag with enable", irq, 1);
    irq_gate = 1'b0;
    #1; chk("R9 global gate off", irq, 0);
    irq_gate = 1'b1;
    wr(3'd0, 8'h80);
    #1; chk("R9 high flag", irq, 1);
    wr(3'd0, 8'h00);
    #1; chk("R9 flags cleared", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule